// File: doc/BRIEF.md
# Triangle Spread-Spectrum Modulation Generator

This block spreads a synthesized clock around its centre frequency by adding a symmetric triangle-shaped offset to the feedback divider word of a frequency synthesizer. It runs on the reference clock and takes one waveform step on every cycle of that clock. Each cycle it presents an adjusted divider word equal to the current nominal word plus the signed offset.

Software controls four inputs. An enable turns the spreading on or off. A 4-bit depth code sets the peak offset as a fraction of the nominal word. A 16-bit quarter length sets how many reference cycles one quarter of the triangle lasts. The nominal divider word is supplied directly. Depth and rate are captured only at the start of each period, where the offset is zero, so a reprogramming never makes the waveform jump. When spreading is disabled, the output falls back to the plain nominal word straight away.

Top module: `ssm_triangle_gen`

## Requirements
- R1: While `rst_n` is low, `div_out` is 0. In every cycle after a rising clock edge at which `mod_en` was low, `div_out` equals the `nominal_div` sampled at that edge, and the waveform returns to its period start.
- R2: The peak offset is P = floor(N_nom * c / 400). Here N_nom is `nominal_div` and c is `depth_code`, both sampled at the period start. Each code step is 0.25 %. Codes 9 to 15 saturate to 8, which is 2 %.
- R3: One triangle period lasts exactly 4*L enabled cycles, where L is `quarter_len`. A `quarter_len` of 0 is treated as L = 1. At the end of each period the offset is back at 0.
- R4: Count the enabled edges since the period start as t = 1..4L. The offset after edge t is one of the following:
  - +floor(t*P/L) for t ≤ L
  - +floor((2L−t)*P/L) for L ≤ t ≤ 2L
  - −floor((t−2L)*P/L) for 2L ≤ t ≤ 3L
  - −floor((4L−t)*P/L) for t ≥ 3L
- R5: The offset is exactly +P at t = L and exactly −P at t = 3L, and the direction reverses at those two points.
- R6: Changes to `depth_code` or `quarter_len` made during a period have no effect until the next period start.
- R7: `div_out` equals the `nominal_div` sampled at the same edge plus the signed offset, one register stage after the inputs. A nominal word that changes mid-period is followed at once.
- R8: With a depth code of 0, `div_out` equals the nominal word on every enabled cycle.
- R9: Dropping `mod_en` in the middle of a period clears the offset. Raising it again starts a fresh period from zero, using the depth and rate present at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one waveform step per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Spreading enable |
| nominal_div | input | 16 | Nominal feedback divider word |
| depth_code | input | 4 | Peak depth in 0.25 % steps, saturating at 8 |
| quarter_len | input | 16 | Reference cycles per quarter period (0 means 1) |
| div_out | output | 17 | Adjusted divider word |

## Verification
The waveform is driven with three depth and rate pairs:
- A peak that divides evenly by the quarter length shows whether the basic ramp and its turning points are correct.
- A peak that leaves a remainder (92 over 7 cycles) shows whether the fractional step is carried exactly instead of rounding drifting over the quarter.
- A quarter length of one, including the zero code, shows that the shortest period alternates between the two peaks.

Further runs cover the following cases:
- Depth and rate changed mid-period, which separates deferred capture from immediate capture.
- A nominal word that changes every cycle, which shows that the output tracks the live word while the peak stays latched.
- A saturating depth code and a zero depth code.
- Disable and re-enable in the middle of a period.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    // Quarter of the triangle period the walker is currently in.
    typedef enum logic [1:0] {
        Q_RISE_POS = 2'd0,
        Q_FALL_POS = 2'd1,
        Q_RISE_NEG = 2'd2,
        Q_FALL_NEG = 2'd3
    } quarter_e;

    function automatic quarter_e quarter_after(input quarter_e cur);
        case (cur)
            Q_RISE_POS: return Q_FALL_POS;
            Q_FALL_POS: return Q_RISE_NEG;
            Q_RISE_NEG: return Q_FALL_NEG;
            default:    return Q_RISE_POS;
        endcase
    endfunction

    function automatic logic is_rising(input quarter_e cur);
        return (cur == Q_RISE_POS) || (cur == Q_RISE_NEG);
    endfunction

    function automatic logic is_negative(input quarter_e cur);
        return (cur == Q_RISE_NEG) || (cur == Q_FALL_NEG);
    endfunction

endpackage

// File: rtl/ssm_depth_calc.sv
// Derives the per-period waveform constants from the live software inputs:
// saturated depth, peak offset, effective quarter length, and the whole and
// fractional parts of the per-cycle step.
module ssm_depth_calc #(
    parameter int DIV_W     = 16,
    parameter int CNT_W     = 16,
    parameter int DEPTH_W   = 4,
    parameter int DEPTH_MAX = 8,
    parameter int DEPTH_DEN = 400
) (
    input  logic [DIV_W-1:0]   nominal_div,
    input  logic [DEPTH_W-1:0] depth_code,
    input  logic [CNT_W-1:0]   quarter_len,
    output logic [DIV_W-1:0]   peak,
    output logic [CNT_W-1:0]   n_eff,
    output logic [DIV_W-1:0]   step_whole,
    output logic [CNT_W-1:0]   step_frac
);
    localparam int PROD_W = DIV_W + DEPTH_W;
    localparam int WIDE_W = DIV_W + CNT_W;

    logic [DEPTH_W-1:0] code_sat;
    logic [PROD_W-1:0]  product;

    always_comb begin
        // R2: codes beyond the 2 % point clamp to it
        code_sat   = (depth_code > DEPTH_W'(DEPTH_MAX)) ? DEPTH_W'(DEPTH_MAX) : depth_code;
        product    = PROD_W'(nominal_div) * PROD_W'(code_sat);
        peak       = DIV_W'(product / PROD_W'(DEPTH_DEN));
        // R3: a zero quarter length behaves as one cycle
        n_eff      = (quarter_len == '0) ? CNT_W'(1) : quarter_len;
        step_whole = DIV_W'(WIDE_W'(peak) / WIDE_W'(n_eff));
        step_frac  = CNT_W'(WIDE_W'(peak) % WIDE_W'(n_eff));
    end

endmodule

// File: rtl/ssm_tri_step.sv
// One step of the triangle walker. The magnitude is kept as
// floor(k*peak/n) with its remainder rem = (k*peak) mod n, so every step
// moves k by one and adjusts magnitude and remainder without a divider.
module ssm_tri_step
    import ssm_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int CNT_W = 16
) (
    input  quarter_e         quarter,
    input  logic [CNT_W-1:0] k,
    input  logic [DIV_W-1:0] mag,
    input  logic [CNT_W-1:0] rem,
    input  logic [CNT_W-1:0] n,
    input  logic [DIV_W-1:0] step_whole,
    input  logic [CNT_W-1:0] step_frac,
    output quarter_e         quarter_n,
    output logic [CNT_W-1:0] k_n,
    output logic [DIV_W-1:0] mag_n,
    output logic [CNT_W-1:0] rem_n
);
    localparam int RW = CNT_W + 1;

    logic [RW-1:0] rem_sum;
    logic          carry;
    logic          borrow;

    always_comb begin
        rem_sum = RW'(rem) + RW'(step_frac);
        carry   = rem_sum >= RW'(n);
        borrow  = rem < step_frac;
        if (is_rising(quarter)) begin
            rem_n     = carry ? CNT_W'(rem_sum - RW'(n)) : CNT_W'(rem_sum);
            mag_n     = mag + step_whole + DIV_W'(carry);
            k_n       = k + CNT_W'(1);
            // R5: turn exactly when the quarter length is reached
            quarter_n = (k_n == n) ? quarter_after(quarter) : quarter;
        end else begin
            rem_n     = borrow ? CNT_W'(RW'(rem) + RW'(n) - RW'(step_frac))
                               : (rem - step_frac);
            mag_n     = mag - step_whole - DIV_W'(borrow);
            k_n       = k - CNT_W'(1);
            quarter_n = (k_n == '0) ? quarter_after(quarter) : quarter;
        end
    end

endmodule

// File: rtl/ssm_triangle_gen.sv
module ssm_triangle_gen
    import ssm_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int CNT_W     = 16,
    parameter int DEPTH_W   = 4,
    parameter int DEPTH_MAX = 8,
    parameter int DEPTH_DEN = 400
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mod_en,
    input  logic [DIV_W-1:0]   nominal_div,
    input  logic [DEPTH_W-1:0] depth_code,
    input  logic [CNT_W-1:0]   quarter_len,
    output logic [DIV_W:0]     div_out
);
    typedef struct packed {
        quarter_e         quarter;
        logic [CNT_W-1:0] k;
        logic [DIV_W-1:0] mag;
        logic [CNT_W-1:0] rem;
        logic [DIV_W-1:0] peak;
        logic [CNT_W-1:0] n;
        logic [DIV_W-1:0] step_whole;
        logic [CNT_W-1:0] step_frac;
        logic [DIV_W:0]   div;
    } state_t;

    state_t st_q, st_d;

    logic             at_start;
    logic [DIV_W-1:0] calc_peak, calc_whole, eff_peak, eff_whole;
    logic [CNT_W-1:0] calc_n, calc_frac, eff_n, eff_frac;
    quarter_e         walk_quarter;
    logic [CNT_W-1:0] walk_k, walk_rem;
    logic [DIV_W-1:0] walk_mag;

    ssm_depth_calc #(
        .DIV_W(DIV_W), .CNT_W(CNT_W), .DEPTH_W(DEPTH_W),
        .DEPTH_MAX(DEPTH_MAX), .DEPTH_DEN(DEPTH_DEN)
    ) i_calc (
        .nominal_div(nominal_div),
        .depth_code (depth_code),
        .quarter_len(quarter_len),
        .peak       (calc_peak),
        .n_eff      (calc_n),
        .step_whole (calc_whole),
        .step_frac  (calc_frac)
    );

    // R6: new constants are taken only where the offset is zero at period start
    assign at_start  = (st_q.quarter == Q_RISE_POS) && (st_q.k == '0);
    assign eff_peak  = at_start ? calc_peak  : st_q.peak;
    assign eff_n     = at_start ? calc_n     : st_q.n;
    assign eff_whole = at_start ? calc_whole : st_q.step_whole;
    assign eff_frac  = at_start ? calc_frac  : st_q.step_frac;

    ssm_tri_step #(
        .DIV_W(DIV_W), .CNT_W(CNT_W)
    ) i_step (
        .quarter   (st_q.quarter),
        .k         (st_q.k),
        .mag       (st_q.mag),
        .rem       (st_q.rem),
        .n         (eff_n),
        .step_whole(eff_whole),
        .step_frac (eff_frac),
        .quarter_n (walk_quarter),
        .k_n       (walk_k),
        .mag_n     (walk_mag),
        .rem_n     (walk_rem)
    );

    always_comb begin
        st_d = st_q;
        if (!mod_en) begin
            // R1, R9: drop the offset at once and rewind to period start
            st_d     = '0;
            st_d.div = {1'b0, nominal_div};
        end else begin
            st_d.peak       = eff_peak;
            st_d.n          = eff_n;
            st_d.step_whole = eff_whole;
            st_d.step_frac  = eff_frac;
            st_d.quarter    = walk_quarter;
            st_d.k          = walk_k;
            st_d.mag        = walk_mag;
            st_d.rem        = walk_rem;
            // R7: live nominal word plus signed offset
            st_d.div        = is_negative(walk_quarter)
                            ? ({1'b0, nominal_div} - {1'b0, walk_mag})
                            : ({1'b0, nominal_div} + {1'b0, walk_mag});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign div_out = st_q.div;

    // R1: a disabled cycle passes the nominal word straight through
    a_r1_disabled_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |=> div_out == {1'b0, $past(nominal_div)});

    // R5: the magnitude never overshoots the latched peak
    a_r5_within_peak: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mag <= st_q.peak);

    // R3: the position inside a quarter never passes the quarter length
    a_r3_within_quarter: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.k <= st_q.n);

    // R4: both zero crossings carry an exactly zero magnitude
    a_r4_zero_crossing: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.k == '0) |-> (st_q.mag == '0));

    // R6: waveform constants hold everywhere except at period start
    a_r6_constants_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && !at_start) |=> (st_q.peak == $past(st_q.peak)) && (st_q.n == $past(st_q.n)));

endmodule

// File: tb/test_ssm_triangle_gen.sv
module test_ssm_triangle_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mod_en = 1'b0;
    logic [15:0] nominal_div = '0;
    logic [3:0]  depth_code = '0;
    logic [15:0] quarter_len = '0;
    logic [16:0] div_out;

    always #5 clk = ~clk;

    ssm_triangle_gen i_ssm_triangle_gen (
        .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .nominal_div(nominal_div),
        .depth_code(depth_code), .quarter_len(quarter_len), .div_out(div_out)
    );

    typedef struct {
        int exp;
        int tag;
    } item_t;

    item_t sb[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    int m_t = 0;
    int m_p = 0;
    int m_n = 1;

    function automatic int tri_off(input int t, input int p, input int n);
        if (t <= n)          return (t * p) / n;
        else if (t <= 2 * n) return ((2 * n - t) * p) / n;
        else if (t <= 3 * n) return -(((t - 2 * n) * p) / n);
        else                 return -(((4 * n - t) * p) / n);
    endfunction

    // driver: applies one cycle of inputs and queues the expected output
    task automatic step(input bit en, input int nom, input int code, input int len, input int tag);
        item_t it;
        @(negedge clk);
        mod_en      = en;
        nominal_div = 16'(nom);
        depth_code  = 4'(code);
        quarter_len = 16'(len);
        it.tag = tag;
        if (!en) begin
            m_t    = 0;
            it.exp = nom;
        end else begin
            if (m_t == 0) begin
                m_p = (nom * ((code > 8) ? 8 : code)) / 400;   // R2
                m_n = (len == 0) ? 1 : len;                     // R3
            end
            m_t = m_t + 1;
            it.exp = nom + tri_off(m_t, m_p, m_n);              // R4
            if (m_t == m_n || m_t == 3 * m_n) it.tag = 5;       // R5 peaks
            if (m_t == 4 * m_n) begin
                m_t = 0;
                it.tag = 3;                                     // R3 period end
            end
        end
        sb.push_back(it);
    endtask

    task automatic run(input int cycles, input bit en, input int nom, input int code,
                       input int len, input int tag);
        for (int i = 0; i < cycles; i++) step(en, nom, code, len, tag);
    endtask

    // monitor: compares each produced word against the queued expectation
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (int'(div_out) != it.exp) begin
                    errors++;
                    $display("FAIL R%0d: div_out=%0d expected %0d", it.tag, div_out, it.exp);
                end
            end
        end
    end

    initial begin
        #(100_000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL R3: watchdog expired, actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        checks++;
        if (div_out != 17'd0) begin
            errors++;
            $display("FAIL R1: div_out=%0d expected 0 in reset", div_out);
        end
        rst_n = 1'b1;

        // R1: disabled passes nominal word, including changes
        run(3, 1'b0, 1000, 8, 5, 1);
        run(2, 1'b0, 54321, 8, 5, 1);

        // R4 / R5: even step, peak 200 over 5 cycles, two periods
        run(40, 1'b1, 10000, 8, 5, 4);
        // R2: saturating code 15 gives the same 2 % peak
        run(20, 1'b1, 10000, 15, 5, 2);
        // R4: fractional step 92 over 7 cycles
        run(28, 1'b1, 12345, 3, 7, 4);
        // R2: mid depth code 5 on a large word
        run(12, 1'b1, 60000, 5, 3, 2);

        // R6: change depth and rate mid-period; old values finish the period
        step(1'b0, 20000, 8, 4, 6);
        run(6, 1'b1, 20000, 8, 4, 6);
        run(22, 1'b1, 20000, 2, 3, 6);

        // R3: quarter length 0 treated as 1
        step(1'b0, 40000, 4, 0, 3);
        run(8, 1'b1, 40000, 4, 0, 3);

        // R8: depth 0 leaves the word untouched
        run(12, 1'b1, 33333, 0, 3, 8);

        // R9: disable mid-period, re-enable with fresh settings
        step(1'b0, 10000, 8, 6, 9);
        run(9, 1'b1, 10000, 8, 6, 9);
        run(2, 1'b0, 10000, 8, 6, 9);
        run(8, 1'b1, 10000, 4, 2, 9);

        // R7: nominal word changing every cycle while enabled
        step(1'b0, 30000, 8, 4, 7);
        for (int i = 0; i < 20; i++) step(1'b1, 30000 + i * 7, 8, 4, 7);

        step(1'b0, 30000, 8, 4, 1);
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule